// File: doc/BRIEF.md
# Layered Reset and Power-Down Controller

This block builds the reset tree of a one-port line interface. An active-low board reset pin, a small register write port and a read port feed two control words. The global word holds a sticky reset bit and a data-path reset bit. The port word holds a sticky reset bit, a data-path reset bit and a power-down bit. From these two words the block derives five levels: global reset, port reset, global data-path reset, port data-path reset and port power-down. Each level sets or clears the levels below it in a fixed order.

A full reset returns configuration to its defaults. A data-path reset leaves configuration alone and clears only status, counters and datapath flops. A small sample of port logic shows the difference. It has a configuration register, a sticky status flag, an event counter and a pair of registered transmit line outputs. The line outputs are held low whenever the data path is in reset.

Top module: `rstc_top`

## Requirements
- R1: The pin passes through a synchronizer that asserts at once and releases after SYNC_STAGES clock edges. `glb_rst` is high while the synchronized pin is low or the global reset bit is 1. The global reset bit is address 0, bit 0. A write of 1 sets it and it stays set. Only a write of 0 or a low pin clears it.
- R2: `rd_oe` is low at every moment the raw pin is low, and high otherwise.
- R3: `port_rst` is the OR of `glb_rst` and the port reset bit (address 1, bit 0). While `glb_rst` is high, the port reset bit is cleared at every edge, and writes to it have no effect.
- R4: At each clock edge where `glb_rst` is high, the global data-path bit (address 0, bit 1) is forced to 1. At each edge where `port_rst` is high, the port data-path bit (address 1, bit 1) and the power-down bit (address 1, bit 2) are forced to 1. After a pin reset, all three bits read 1.
- R5: A data-path or power-down bit goes from 1 to 0 only through a write of 0 at an edge where `port_rst` is low. A write of 0 at an edge where `port_rst` is high leaves the bit at 1.
- R6: `glb_dp_rst` equals the global data-path bit. `port_dp_rst` is the OR of both data-path bits. `port_pd` equals the power-down bit.
- R7: `rd_data` shows the word selected by `rd_addr`. Address 0 gives {glb dp, glb rst} in bits 1:0. Address 1 gives {pd, dp, rst} in bits 2:0. Address 2 gives the sample configuration register. All other bits read 0.
- R8: While `port_dp_rst` or `port_rst` is high, `tx_pos` and `tx_neg` are 0. Otherwise they show the line inputs one edge late.
- R9: At every edge where `port_dp_rst` or `port_rst` is high, `ev_count` and `sts_flag` are cleared, and `ev_inc` and `sts_set` are ignored. Otherwise `ev_count` counts `ev_inc` cycles and `sts_flag` latches `sts_set`. A data-path reset leaves the configuration register (address 2) unchanged.
- R10: The configuration register loads `wr_data` on a write to address 2. It is cleared at every edge where `port_rst` is high.
- R11: A write takes effect at the rising edge that samples `wr_en`. Its result is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |
| rd_oe | output | 1 | Read data drive enable, low while pin is low |
| glb_rst | output | 1 | Global reset level |
| port_rst | output | 1 | Port reset level |
| glb_dp_rst | output | 1 | Global data-path reset level |
| port_dp_rst | output | 1 | Port data-path reset level |
| port_pd | output | 1 | Port power-down level |
| ev_inc | input | 1 | Sample event pulse |
| sts_set | input | 1 | Sample status set pulse |
| tx_pos_in | input | 1 | Positive line data in |
| tx_neg_in | input | 1 | Negative line data in |
| ev_count | output | CNT_W | Sample event count |
| sts_flag | output | 1 | Sample sticky status |
| tx_pos | output | 1 | Positive line data out |
| tx_neg | output | 1 | Negative line data out |

## Verification
The assertions assume that `ext_rst_n` is low at time zero. While the pin is low, or before the first edge, they hold nothing. They also assume that `wr_addr` and `wr_data` are stable and defined around each edge at which `wr_en` is high. The stimulus meets both conditions. It starts with the pin low and changes every input only a short time after a rising edge. Every write lasts one full clock cycle, and the pin moves only away from clock edges.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int ADDR_GLB  = 0;
  localparam int ADDR_PORT = 1;
  localparam int ADDR_CFG  = 2;
  localparam int BIT_RST   = 0;
  localparam int BIT_DP    = 1;
  localparam int BIT_PD    = 2;
  localparam int CTL_W     = 3;

  typedef struct packed {
    logic glb_rst;
    logic glb_dp;
    logic prt_rst;
    logic prt_dp;
    logic prt_pd;
  } ctl_bits_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs #(
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     sys_rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [rstc_pkg::CTL_W-1:0] wr_bits,
  output rstc_pkg::ctl_bits_t      bits,
  output logic                     glb_rst,
  output logic                     port_rst
);
  import rstc_pkg::*;

  ctl_bits_t bits_q, bits_d;
  logic wr_glb, wr_prt;

  assign glb_rst  = ~sys_rst_n | bits_q.glb_rst;
  assign port_rst = glb_rst | bits_q.prt_rst;
  assign wr_glb   = wr_en && (wr_addr == ADDR_W'(ADDR_GLB));
  assign wr_prt   = wr_en && (wr_addr == ADDR_W'(ADDR_PORT));

  always_comb begin
    bits_d = bits_q;
    if (wr_glb) bits_d.glb_rst = wr_bits[BIT_RST];

    if (glb_rst)
      bits_d.glb_dp = 1'b1;
    else if (wr_glb && (wr_bits[BIT_DP] || !port_rst))
      bits_d.glb_dp = wr_bits[BIT_DP];

    if (glb_rst)     bits_d.prt_rst = 1'b0;
    else if (wr_prt) bits_d.prt_rst = wr_bits[BIT_RST];

    if (port_rst) begin
      bits_d.prt_dp = 1'b1;
      bits_d.prt_pd = 1'b1;
    end else if (wr_prt) begin
      bits_d.prt_dp = wr_bits[BIT_DP];
      bits_d.prt_pd = wr_bits[BIT_PD];
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      bits_q.glb_rst <= 1'b0;
      bits_q.glb_dp  <= 1'b1;
      bits_q.prt_rst <= 1'b0;
      bits_q.prt_dp  <= 1'b1;
      bits_q.prt_pd  <= 1'b1;
    end else begin
      bits_q <= bits_d;
    end
  end

  assign bits = bits_q;
endmodule

// File: rtl/rstc_port_demo.sv
module rstc_port_demo #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              port_rst,
  input  logic              dp_clear,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ev_inc,
  input  logic              sts_set,
  input  logic              tx_pos_in,
  input  logic              tx_neg_in,
  output logic [DATA_W-1:0] cfg,
  output logic              sts_flag,
  output logic [CNT_W-1:0]  ev_count,
  output logic              tx_pos,
  output logic              tx_neg
);
  logic [DATA_W-1:0] cfg_q, cfg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sts_q, sts_d;
  logic [1:0]        tx_q, tx_d;

  always_comb begin
    cfg_d = cfg_q;
    if (port_rst)    cfg_d = '0;
    else if (cfg_we) cfg_d = cfg_wdata;

    if (dp_clear) begin
      cnt_d = '0;
      sts_d = 1'b0;
      tx_d  = 2'b00;
    end else begin
      cnt_d = ev_inc ? cnt_q + CNT_W'(1) : cnt_q;
      sts_d = sts_q | sts_set;
      tx_d  = {tx_pos_in, tx_neg_in};
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      sts_q <= 1'b0;
      tx_q  <= 2'b00;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
      sts_q <= sts_d;
      tx_q  <= tx_d;
    end
  end

  assign cfg      = cfg_q;
  assign ev_count = cnt_q;
  assign sts_flag = sts_q;
  assign tx_pos   = tx_q[1] & ~dp_clear;
  assign tx_neg   = tx_q[0] & ~dp_clear;
endmodule

// File: rtl/rstc_top.sv
module rstc_top #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              glb_rst,
  output logic              port_rst,
  output logic              glb_dp_rst,
  output logic              port_dp_rst,
  output logic              port_pd,
  input  logic              ev_inc,
  input  logic              sts_set,
  input  logic              tx_pos_in,
  input  logic              tx_neg_in,
  output logic [CNT_W-1:0]  ev_count,
  output logic              sts_flag,
  output logic              tx_pos,
  output logic              tx_neg
);
  import rstc_pkg::*;

  logic              sys_rst_n;
  ctl_bits_t         bits;
  logic              dp_clear;
  logic [DATA_W-1:0] cfg;

  rstc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .arst_n(ext_rst_n), .rst_n(sys_rst_n)
  );

  rstc_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[CTL_W-1:0]), .bits(bits),
    .glb_rst(glb_rst), .port_rst(port_rst)
  );

  assign glb_dp_rst  = bits.glb_dp;
  assign port_dp_rst = bits.glb_dp | bits.prt_dp;
  assign port_pd     = bits.prt_pd;
  assign dp_clear    = port_rst | port_dp_rst;
  assign rd_oe       = ext_rst_n;

  rstc_port_demo #(.DATA_W(DATA_W), .CNT_W(CNT_W)) demo_i (
    .clk(clk), .sys_rst_n(sys_rst_n), .port_rst(port_rst), .dp_clear(dp_clear),
    .cfg_we(wr_en && (wr_addr == ADDR_W'(ADDR_CFG))), .cfg_wdata(wr_data),
    .ev_inc(ev_inc), .sts_set(sts_set), .tx_pos_in(tx_pos_in),
    .tx_neg_in(tx_neg_in), .cfg(cfg), .sts_flag(sts_flag),
    .ev_count(ev_count), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_GLB)) begin
      rd_data[BIT_RST] = bits.glb_rst;
      rd_data[BIT_DP]  = bits.glb_dp;
    end else if (rd_addr == ADDR_W'(ADDR_PORT)) begin
      rd_data[BIT_RST] = bits.prt_rst;
      rd_data[BIT_DP]  = bits.prt_dp;
      rd_data[BIT_PD]  = bits.prt_pd;
    end else if (rd_addr == ADDR_W'(ADDR_CFG)) begin
      rd_data = cfg;
    end
  end
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              ext_rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_pd_bit,
  input logic              rd_oe,
  input logic              glb_rst,
  input logic              port_rst,
  input logic              glb_dp_rst,
  input logic              port_dp_rst,
  input logic              port_pd,
  input logic [CNT_W-1:0]  ev_count,
  input logic              tx_pos,
  input logic              tx_neg
);
  always_comb begin
    if (ext_rst_n === 1'b0) AST_OE_OFF_IN_RESET: assert (rd_oe === 1'b0); // R2
  end

  AST_PORT_COVERS_GLOBAL: assert property (@(posedge clk) disable iff (!ext_rst_n)
    glb_rst |-> port_rst); // R3

  AST_GLB_DP_FORCED: assert property (@(posedge clk) disable iff (!ext_rst_n)
    glb_rst |=> glb_dp_rst); // R4

  AST_PORT_DP_PD_FORCED: assert property (@(posedge clk) disable iff (!ext_rst_n)
    port_rst |=> (port_dp_rst && port_pd)); // R4

  AST_PD_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $fell(port_pd) |-> $past(wr_en && (wr_addr == ADDR_W'(rstc_pkg::ADDR_PORT)) && !wr_pd_bit && !port_rst)); // R5

  AST_DP_OR: assert property (@(posedge clk) disable iff (!ext_rst_n)
    glb_dp_rst |-> port_dp_rst); // R6

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (port_dp_rst || port_rst) |-> (!tx_pos && !tx_neg)); // R8

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!ext_rst_n)
    port_dp_rst |=> (ev_count == '0)); // R9
endmodule

bind rstc_top rstc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .ext_rst_n(ext_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_pd_bit(wr_data[rstc_pkg::BIT_PD]), .rd_oe(rd_oe), .glb_rst(glb_rst),
  .port_rst(port_rst), .glb_dp_rst(glb_dp_rst), .port_dp_rst(port_dp_rst),
  .port_pd(port_pd), .ev_count(ev_count), .tx_pos(tx_pos), .tx_neg(tx_neg)
);

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
  logic       clk = 1'b0;
  logic       ext_rst_n, wr_en, ev_inc, sts_set, tx_pos_in, tx_neg_in;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data, ev_count;
  logic       rd_oe, glb_rst, port_rst, glb_dp_rst, port_dp_rst, port_pd;
  logic       sts_flag, tx_pos, tx_neg;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rstc_top dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe),
    .glb_rst(glb_rst), .port_rst(port_rst), .glb_dp_rst(glb_dp_rst),
    .port_dp_rst(port_dp_rst), .port_pd(port_pd), .ev_inc(ev_inc),
    .sts_set(sts_set), .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
    .ev_count(ev_count), .sts_flag(sts_flag), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  // {wr_en, addr, data, expected {glb, port, gdp, pdp, pd}}
  localparam int NV = 18;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 5'b00011}, {1'b1, 2'd1, 8'h00, 5'b00000},
    {1'b1, 2'd1, 8'h04, 5'b00001}, {1'b1, 2'd1, 8'h02, 5'b00010},
    {1'b1, 2'd1, 8'h00, 5'b00000}, {1'b1, 2'd1, 8'h01, 5'b01000},
    {1'b0, 2'd0, 8'h00, 5'b01011}, {1'b1, 2'd1, 8'h00, 5'b00011},
    {1'b1, 2'd1, 8'h00, 5'b00000}, {1'b1, 2'd0, 8'h01, 5'b11000},
    {1'b0, 2'd0, 8'h00, 5'b11111}, {1'b1, 2'd0, 8'h00, 5'b00111},
    {1'b1, 2'd0, 8'h00, 5'b00011}, {1'b1, 2'd1, 8'h00, 5'b00000},
    {1'b1, 2'd1, 8'h01, 5'b01000}, {1'b1, 2'd0, 8'h01, 5'b11011},
    {1'b0, 2'd0, 8'h00, 5'b11111}, {1'b1, 2'd0, 8'h00, 5'b00111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  function automatic logic [4:0] lv();
    return {glb_rst, port_rst, glb_dp_rst, port_dp_rst, port_pd};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ext_rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    ev_inc = 1'b0; sts_set = 1'b0; tx_pos_in = 1'b0; tx_neg_in = 1'b0;
    #1;
    chk("R2 oe low in reset", rd_oe, 1'b0);
    chk("R1 glb_rst at pin", glb_rst, 1'b1);
    cyc(); cyc();
    ext_rst_n = 1'b1;
    cyc();
    chk("R1 sync holds reset", glb_rst, 1'b1);
    cyc(); cyc();
    chk("R4 reset state levels", lv(), 5'b00111);
    chk("R2 oe high", rd_oe, 1'b1);

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i][15]; wr_addr = VEC[i][14:13]; wr_data = VEC[i][12:5];
      cyc();
      wr_en = 1'b0;
      chk($sformatf("R11 R3 R4 R5 R6 vector %0d", i), lv(), VEC[i][4:0]);
    end

    rd_addr = 2'd1; #1;
    chk("R7 read port word", rd_data, 8'h06);
    rd_addr = 2'd0; #1;
    chk("R7 read global word", rd_data, 8'h02);

    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    chk("R6 all levels low", lv(), 5'b00000);
    wr(2'd2, 8'h5A);
    rd_addr = 2'd2; #1;
    chk("R10 cfg write", rd_data, 8'h5A);
    ev_inc = 1'b1; sts_set = 1'b1; tx_pos_in = 1'b1;
    cyc(); sts_set = 1'b0;
    cyc(); cyc();
    chk("R9 count events", ev_count, 8'd3);
    chk("R9 status latched", sts_flag, 1'b1);
    chk("R8 tx follows input", {tx_pos, tx_neg}, 2'b10);

    wr(2'd1, 8'h02);
    chk("R8 tx forced low", {tx_pos, tx_neg}, 2'b00);
    chk("R11 count at write edge", ev_count, 8'd4);
    cyc(); cyc(); cyc();
    chk("R9 count cleared and frozen", ev_count, 8'd0);
    chk("R9 status cleared", sts_flag, 1'b0);
    chk("R9 cfg kept under dp reset", rd_data, 8'h5A);
    ev_inc = 1'b0;

    wr(2'd1, 8'h00);
    chk("R8 tx low one edge after release", tx_pos, 1'b0);
    cyc();
    chk("R8 tx resumes", tx_pos, 1'b1);

    wr(2'd1, 8'h01);
    chk("R3 port reset from bit", port_rst, 1'b1);
    cyc();
    chk("R10 cfg cleared by port reset", rd_data, 8'h00);
    wr(2'd1, 8'h00);

    wr(2'd0, 8'h01);
    chk("R1 sticky global bit", glb_rst, 1'b1);
    cyc(); cyc();
    chk("R1 global bit holds", glb_rst, 1'b1);
    #5 ext_rst_n = 1'b0;
    #1;
    chk("R2 oe drops with pin", rd_oe, 1'b0);
    chk("R1 glb_rst with pin", glb_rst, 1'b1);
    cyc(); cyc();
    #3 ext_rst_n = 1'b1;
    cyc(); cyc(); cyc();
    chk("R1 pin cleared global bit", lv(), 5'b00111);
    rd_addr = 2'd0; #1;
    chk("R7 global word after pin", rd_data, 8'h02);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule